// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block lets one external master take over the primary bus. The master asks with an active-low, asynchronous hold request. The block synchronizes that request and waits until any transaction already on the bus has finished. It then floats the strobe, read/write, address and data drivers and answers with an active-low acknowledge. A no-hold control bit overrides the mechanism. While the bit is set, requests are ignored, and setting it during a hold ends that hold at once.

The core is not frozen while the bus is held. The block stalls the core only when the core actually needs the primary bus. A single write may be parked so that it waits for the bus without stalling. A read, or a second write while one is already parked, stalls the core. The bus cycle controller tells the block whether a transaction is in progress and whether an access is being requested. The block tells the controller when a new bus cycle may start.

Top module: `bus_hold_arbiter`

## Requirements
- R1: The acknowledge (`hold_ack_n`) falls only after a clock edge at which `xact_busy` was low. A transaction in progress holds off the release of the bus until it has ended.
- R2: While `hold_ack_n` is low, `drv_float` is 1 and `cycle_ok` is 0.
- R3: `hold_req_n` passes through a two-stage synchronizer. With `nohold` at 0 and `xact_busy` at 0, `hold_ack_n` goes low after the third rising edge that follows `hold_req_n` going low, and not before.
- R4: While `nohold` is 1, a low `hold_req_n` has no effect. `hold_ack_n` stays 1 and `drv_float` stays 0.
- R5: If `nohold` is 1 at a rising edge while the bus is held, `hold_ack_n` returns to 1 and `drv_float` to 0 after that edge, even though `hold_req_n` is still low.
- R6: While `cycle_ok` is 0, a read access (`acc_req`=1, `acc_wr`=0) raises `core_stall` in the same cycle.
- R7: While `cycle_ok` is 0 and no write is parked, a write access (`acc_req`=1, `acc_wr`=1) does not stall. It sets `wr_parked` at the next edge. A write seen while `wr_parked` is 1 and `cycle_ok` is 0 stalls. `wr_parked` clears at the first edge at which `cycle_ok` is 1.
- R8: After `hold_req_n` returns high, `hold_ack_n` stays low through the third rising edge and returns high after the fourth.
- R9: `cycle_ok` is 0 whenever a synchronized request is pending with `nohold` at 0, or the bus is held. It returns to 1 in the same cycle as `hold_ack_n` rises and `drv_float` falls.
- R10: After reset, `hold_ack_n`=1, `drv_float`=0, `cycle_ok`=1, `core_stall`=0 and `wr_parked`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low hold request from the external master |
| nohold | input | 1 | Control bit: ignore requests and leave any active hold |
| xact_busy | input | 1 | Bus cycle controller: a transaction is in progress |
| acc_req | input | 1 | Bus cycle controller: the core requests a primary-bus access |
| acc_wr | input | 1 | The requested access is a write (1) or a read (0) |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| drv_float | output | 1 | Puts the strobe, read/write, address and data drivers in high impedance |
| cycle_ok | output | 1 | A new primary-bus cycle may start |
| core_stall | output | 1 | Stall to the core |
| wr_parked | output | 1 | One write is parked and waiting for the bus |

## Verification
The hardest case to reach from the ports is a hold request that reaches the synchronizer output while a transaction is still in progress. The bus must stay owned, with new cycles already blocked, until `xact_busy` drops. A directed sequence holds `xact_busy` high across the synchronizer delay and then releases it. A second hard case is the write-parking path: a first write inside a hold, then a second write stacked behind it, then the parked write draining once the bus comes back. The directed steps cover this too. A random phase then mixes request pulses of every length, busy windows, rare `nohold` toggles and core accesses against a cycle model held in the bench.

// File: rtl/hold_arb_pkg.sv
// Shared types for the bus hold request arbiter.
package hold_arb_pkg;

    // Bus ownership phases.
    typedef enum logic [1:0] {
        ARB_OWN  = 2'd0,   // core owns the bus
        ARB_HELD = 2'd1,   // external master owns the bus
        ARB_TAIL = 2'd2    // request dropped, acknowledge still low
    } arb_state_t;

endpackage

// File: rtl/hold_arb_sync.sv
// Multi-stage synchronizer for the asynchronous active-low hold request.
// Assumes: the input may change at any time relative to clk; the output is
// the inverted (active-high) request, delayed by STAGES edges.
module hold_arb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic req_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the inverted raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= ~req_n_async;
                end
            end else begin : g_next
                // Shift through the remaining stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign req_sync = chain[STAGES-1];
endmodule

// File: rtl/hold_arb_fsm.sv
// Ownership state machine: grants the bus to the external master once no
// transaction is in progress, keeps the acknowledge low for TAIL_CYCLES after
// the request drops, and leaves the hold at once when nohold is set.
// Assumes: req is already synchronized.
module hold_arb_fsm
    import hold_arb_pkg::*;
#(
    parameter int TAIL_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic nohold,
    input  logic xact_busy,
    output logic hold_ack_n,
    output logic drv_float,
    output logic cycle_ok
);
    localparam int CW = $clog2(TAIL_CYCLES + 1);
    localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CYCLES - 1);

    arb_state_t      st, st_nx;
    logic [CW-1:0]   tail_cnt;
    logic            want;

    assign want = req && !nohold;

    // Next-state selection.
    always_comb begin
        st_nx = st;
        unique case (st)
            ARB_OWN:  if (want && !xact_busy) st_nx = ARB_HELD;
            ARB_HELD: if (nohold)             st_nx = ARB_OWN;
                      else if (!req)          st_nx = ARB_TAIL;
            ARB_TAIL: if (nohold || tail_cnt == TAIL_LAST) st_nx = ARB_OWN;
            default:                          st_nx = ARB_OWN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ARB_OWN;
        else        st <= st_nx;
    end

    // Count the cycles spent in the acknowledge tail.
    always_ff @(posedge clk) begin
        if (!rst_n || st != ARB_TAIL) tail_cnt <= '0;
        else                          tail_cnt <= tail_cnt + 1'b1;
    end

    assign hold_ack_n = (st == ARB_OWN);
    assign drv_float  = (st != ARB_OWN);
    assign cycle_ok   = (st == ARB_OWN) && !want;

    assert_release_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> !$past(xact_busy));
    assert_no_cycle_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> !cycle_ok);
    assert_nohold_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nohold && hold_ack_n) |=> hold_ack_n);
    assert_nohold_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nohold && !hold_ack_n) |=> (hold_ack_n && !drv_float));
endmodule

// File: rtl/hold_arb_park.sv
// Core access gating while the bus is unavailable: parks one write without
// stalling, stalls on reads and on a second write.
// Assumes: a parked write is launched by the bus cycle controller in the
// first cycle that cycle_ok is high.
module hold_arb_park (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_ok,
    input  logic acc_req,
    input  logic acc_wr,
    output logic core_stall,
    output logic wr_parked
);
    logic blocked;

    assign blocked    = !cycle_ok;
    assign core_stall = blocked && acc_req && (!acc_wr || wr_parked);

    // Track the single parked write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      wr_parked <= 1'b0;
        else if (cycle_ok)                               wr_parked <= 1'b0;
        else if (acc_req && acc_wr)                      wr_parked <= 1'b1;
    end

    assert_stall_needs_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> acc_req);
    assert_park_only_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_parked) |-> !$past(cycle_ok));
endmodule

// File: rtl/bus_hold_arbiter.sv
// Top of the bus hold request arbiter: synchronizer, ownership state
// machine and core access gating.
// Assumes: hold_req_n is asynchronous; all other inputs are synchronous.
module bus_hold_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAIL_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic nohold,
    input  logic xact_busy,
    input  logic acc_req,
    input  logic acc_wr,
    output logic hold_ack_n,
    output logic drv_float,
    output logic cycle_ok,
    output logic core_stall,
    output logic wr_parked
);
    logic req_s;

    hold_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n_async(hold_req_n), .req_sync(req_s)
    );

    hold_arb_fsm #(.TAIL_CYCLES(TAIL_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req_s), .nohold(nohold),
        .xact_busy(xact_busy), .hold_ack_n(hold_ack_n),
        .drv_float(drv_float), .cycle_ok(cycle_ok)
    );

    hold_arb_park u_park (
        .clk(clk), .rst_n(rst_n), .cycle_ok(cycle_ok), .acc_req(acc_req),
        .acc_wr(acc_wr), .core_stall(core_stall), .wr_parked(wr_parked)
    );

    assert_float_tracks_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_ok |-> (hold_ack_n && !drv_float));
endmodule

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b1, nohold = 1'b0, xact_busy = 1'b0;
    logic acc_req = 1'b0, acc_wr = 1'b0;
    logic hold_ack_n, drv_float, cycle_ok, core_stall, wr_parked;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hold_arbiter u_bus_hold_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .nohold(nohold),
        .xact_busy(xact_busy), .acc_req(acc_req), .acc_wr(acc_wr),
        .hold_ack_n(hold_ack_n), .drv_float(drv_float), .cycle_ok(cycle_ok),
        .core_stall(core_stall), .wr_parked(wr_parked)
    );

    // Cycle model built from the requirements (0 own, 1 held, 2 tail).
    logic m_s1 = 1'b0, m_s2 = 1'b0, m_park = 1'b0;
    int   m_st = 0;

    function automatic bit f_ok(int st, bit s2, bit nh);
        return (st == 0) && !(s2 && !nh);
    endfunction

    function automatic bit f_stall(bit ok, bit rq, bit wr, bit pk);
        return !ok && rq && (!wr || pk);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_st <= 0; m_park <= 1'b0;
        end else begin
            m_s1 <= ~hold_req_n;
            m_s2 <= m_s1;
            if (f_ok(m_st, m_s2, nohold)) m_park <= 1'b0;
            else if (acc_req && acc_wr)   m_park <= 1'b1;
            case (m_st)
                0: if (m_s2 && !nohold && !xact_busy) m_st <= 1;
                1: if (nohold) m_st <= 0; else if (!m_s2) m_st <= 2;
                default: m_st <= 0;
            endcase
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_cmp(string req);
        logic ok;
        ok = f_ok(m_st, m_s2, nohold);
        chk(req, "hold_ack_n", hold_ack_n, m_st == 0);
        chk(req, "drv_float", drv_float, m_st != 0);
        chk(req, "cycle_ok", cycle_ok, ok);
        chk(req, "core_stall", core_stall, f_stall(ok, acc_req, acc_wr, m_park));
        chk(req, "wr_parked", wr_parked, m_park);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        chk("R10", "ack", hold_ack_n, 1'b1);
        chk("R10", "float", drv_float, 1'b0);
        chk("R10", "cycle_ok", cycle_ok, 1'b1);
        chk("R10", "stall", core_stall, 1'b0);
        chk("R10", "parked", wr_parked, 1'b0);

        // R3 entry latency through the synchronizer
        hold_req_n = 1'b0;
        step(2);
        chk("R3", "ack early", hold_ack_n, 1'b1);
        chk("R9", "cycle_ok blocked while pending", cycle_ok, 1'b0);
        step(1);
        chk("R3", "ack low", hold_ack_n, 1'b0);
        chk("R2", "float", drv_float, 1'b1);
        chk("R2", "cycle_ok", cycle_ok, 1'b0);

        // R6 read stalls, R7 write parking
        acc_req = 1'b1; acc_wr = 1'b0;
        #1 chk("R6", "read stall", core_stall, 1'b1);
        acc_wr = 1'b1;
        #1 chk("R7", "first write no stall", core_stall, 1'b0);
        step(1);
        chk("R7", "parked set", wr_parked, 1'b1);
        chk("R7", "second write stalls", core_stall, 1'b1);
        acc_req = 1'b0; acc_wr = 1'b0;

        // R8 acknowledge tail
        hold_req_n = 1'b1;
        step(3);
        chk("R8", "ack still low", hold_ack_n, 1'b0);
        step(1);
        chk("R8", "ack high", hold_ack_n, 1'b1);
        chk("R9", "cycle_ok with ack", cycle_ok, 1'b1);
        chk("R9", "float off", drv_float, 1'b0);
        chk("R7", "parked kept until edge", wr_parked, 1'b1);
        step(1);
        chk("R7", "parked drained", wr_parked, 1'b0);

        // R1 busy transaction defers release
        xact_busy = 1'b1; hold_req_n = 1'b0;
        step(4);
        chk("R1", "busy holds ack", hold_ack_n, 1'b1);
        chk("R9", "blocked during busy", cycle_ok, 1'b0);
        xact_busy = 1'b0;
        step(1);
        chk("R1", "ack after busy ends", hold_ack_n, 1'b0);

        // R5 nohold during hold
        nohold = 1'b1;
        step(1);
        chk("R5", "ack released", hold_ack_n, 1'b1);
        chk("R5", "float off", drv_float, 1'b0);
        step(5);
        chk("R4", "request ignored", hold_ack_n, 1'b1);
        chk("R4", "float stays off", drv_float, 1'b0);
        chk("R4", "cycle_ok", cycle_ok, 1'b1);
        hold_req_n = 1'b1;
        step(4);
        nohold = 1'b0;
        step(1);

        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 5) == 0) hold_req_n = ~hold_req_n;
            nohold    = ($urandom_range(0, 40) == 0);
            xact_busy = ($urandom_range(0, 3) == 0);
            acc_req   = $urandom_range(0, 1);
            acc_wr    = $urandom_range(0, 1);
            #1 model_cmp("R1 R2 R6 R7 R9");
            step(1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule